// File: doc/BRIEF.md
# Optical-Black Clamp Level Averager

This block derives a DC clamp reference from the black rows of an image sensor stream. Each clock it sees one 10-bit converted sample and a marker signal that flags the optically shielded pixels. The marker's active level is set by a polarity-select input. The marker must stay active for at least three sampled clocks to count as valid. Once it does, the block waits a fixed number of clocks and then sums eight consecutive samples. The sum is divided by eight to give the mean, which is published as the clamp level.

The clamp level holds steady between windows. Each time it takes a new value, a one-clock strobe goes high. A marker edge that arrives while a window is still running does not restart it. Downstream logic subtracts the clamp level from the active pixels, or feeds it to an analog clamp loop.

Top module: `ob_clamp_avg`

## Requirements
- R1: After reset, `clamp_o` is 0, `clamp_upd_o` is 0 and no window is open.
- R2: The marker is active when `ob_mark_i` differs from `ob_inv_i`. With `ob_inv_i`=0 the marker is active-high, and with `ob_inv_i`=1 it is active-low.
- R3: Offset 0 is the clock at which the marker is first sampled active after being inactive. Exactly eight samples are summed, taken at offsets 5 through 12.
- R4: The new clamp value is the sum of the eight samples shifted right by 3 (floor of the mean). No rounding is applied, and a full-scale input of 1023 gives 1023.
- R5: The marker must be sampled active at offsets 0, 1 and 2. If it is inactive at offset 1 or 2, the block returns to idle and the clamp level does not change.
- R6: `clamp_o` changes value only in a cycle where `clamp_upd_o` is high. At all other times it holds its previous value.
- R7: The new clamp value appears after the clock edge at offset 13. `clamp_upd_o` is high for exactly that one cycle.
- R8: Marker edges from offset 1 through offset 13 of an open window are ignored. A new inactive-to-active transition sampled at offset 14 or later starts a new window.
- R9: A marker held active for many clocks starts exactly one window. A fresh inactive-to-active transition is needed to start another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| pix_i | input | 10 | Converted pixel sample |
| ob_mark_i | input | 1 | Optical-black marker |
| ob_inv_i | input | 1 | Marker polarity select (1 = active-low) |
| clamp_o | output | 10 | Clamp reference level (mean of the last window) |
| clamp_upd_o | output | 1 | One-cycle strobe marking a new clamp value |

## Verification
Offsets are counted from the clock edge at which the marker is first sampled active. Samples are consumed at edges 5 to 12. The clamp value and the strobe change together just after edge 13. A rejected short pulse or an ignored edge must leave both outputs untouched at every edge.

The bench changes its inputs on the falling clock edge. It compares both outputs, at every falling edge, against a behavioural model that steps on the rising edge. Each output is therefore checked half a cycle after the edge that produced it. After each scenario, the bench also checks the settled clamp value against a hand-computed mean and checks how many strobes it counted.

// File: rtl/ob_clamp_pkg.sv
package ob_clamp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_QUAL = 3'd1,
    ST_WAIT = 3'd2,
    ST_ACC  = 3'd3,
    ST_DONE = 3'd4
  } win_st_e;

endpackage

// File: rtl/ob_rst_sync.sv
module ob_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/ob_mark_edge.sv
module ob_mark_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mark_i,
  input  logic inv_i,
  output logic act_o,
  output logic rise_o
);

  logic prev_q;
  logic prev_d;
  logic act;

  // R2: polarity select folds into a single active-high view
  assign act = mark_i ^ inv_i;

  always_comb begin
    prev_d = act;
  end

  // previous level resets to "active" so a marker held through reset is no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign act_o  = act;
  assign rise_o = act & ~prev_q;

endmodule

// File: rtl/ob_win_ctrl.sv
module ob_win_ctrl
  import ob_clamp_pkg::*;
#(
  parameter int QUAL_CYC  = 3,   // clocks the marker must be seen active (>= 2)
  parameter int WIN_START = 5,   // first sampled offset (> QUAL_CYC)
  parameter int SAMPLES   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic rise_i,
  output logic acc_en_o,
  output logic acc_first_o,
  output logic done_o
);

  localparam int WIN_END = WIN_START + SAMPLES - 1;
  localparam int CNT_W   = $clog2(WIN_END + 2);
  localparam int CHK_W   = $clog2(SAMPLES + 1);

  localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WIN_START - 1);
  localparam logic [CNT_W-1:0] ACC_FIRST = CNT_W'(WIN_START);
  localparam logic [CNT_W-1:0] ACC_LAST  = CNT_W'(WIN_END);

  win_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seq_en;

  // clock enable: sequencer only moves while busy or on a fresh edge
  assign seq_en = (st_q != ST_IDLE) | rise_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (rise_i) begin
          st_d  = ST_QUAL;
          cnt_d = CNT_W'(1);
        end
      end
      ST_QUAL: begin
        if (!act_i) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == QUAL_LAST) st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == WAIT_LAST) st_d = ST_ACC;
      end
      ST_ACC: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == ACC_LAST) st_d = ST_DONE;
      end
      ST_DONE: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (seq_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign acc_en_o    = (st_q == ST_ACC);
  assign acc_first_o = (st_q == ST_ACC) && (cnt_q == ACC_FIRST);
  assign done_o      = (st_q == ST_DONE);

  // checking aid: samples taken during the current window
  logic [CHK_W-1:0] chk_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= '0;
    end else if (st_q == ST_IDLE) begin
      chk_q <= '0;
    end else if (acc_en_o) begin
      chk_q <= chk_q + CHK_W'(1);
    end
  end

  assert_eight_samples_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (chk_q == CHK_W'(SAMPLES)));

  assert_qual_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_QUAL) |-> $past(act_i));

  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT || st_q == ST_ACC || st_q == ST_DONE) |=> (st_q != ST_QUAL));

endmodule

// File: rtl/ob_acc_avg.sv
module ob_acc_avg #(
  parameter int DATA_W   = 10,
  parameter int AVG_LOG2 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pix_i,
  input  logic              acc_en_i,
  input  logic              first_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] clamp_o,
  output logic              upd_o
);

  localparam int ACC_W = DATA_W + AVG_LOG2;

  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [DATA_W-1:0] clamp_q, clamp_d;
  logic              upd_q, upd_d;

  always_comb begin
    acc_d = first_i ? ACC_W'(pix_i) : (acc_q + ACC_W'(pix_i));
  end

  always_comb begin
    clamp_d = done_i ? acc_q[ACC_W-1:AVG_LOG2] : clamp_q;
    upd_d   = done_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (acc_en_i) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clamp_q <= '0;
      upd_q   <= 1'b0;
    end else begin
      clamp_q <= clamp_d;
      upd_q   <= upd_d;
    end
  end

  assign clamp_o = clamp_q;
  assign upd_o   = upd_q;

  assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q);

  assert_clamp_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_q != $past(clamp_q)) |-> upd_q);

endmodule

// File: rtl/ob_clamp_avg.sv
module ob_clamp_avg #(
  parameter int DATA_W    = 10,
  parameter int AVG_LOG2  = 3,
  parameter int QUAL_CYC  = 3,
  parameter int WIN_START = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pix_i,
  input  logic              ob_mark_i,
  input  logic              ob_inv_i,
  output logic [DATA_W-1:0] clamp_o,
  output logic              clamp_upd_o
);

  localparam int SAMPLES = 1 << AVG_LOG2;

  logic rst_int_n;
  logic act, rise;
  logic acc_en, acc_first, done;

  ob_rst_sync u_rst (
    .clk_i   (clk),
    .arst_ni (rst_n),
    .rst_no  (rst_int_n)
  );

  ob_mark_edge u_edge (
    .clk_i  (clk),
    .rst_ni (rst_int_n),
    .mark_i (ob_mark_i),
    .inv_i  (ob_inv_i),
    .act_o  (act),
    .rise_o (rise)
  );

  ob_win_ctrl #(
    .QUAL_CYC  (QUAL_CYC),
    .WIN_START (WIN_START),
    .SAMPLES   (SAMPLES)
  ) u_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_int_n),
    .act_i       (act),
    .rise_i      (rise),
    .acc_en_o    (acc_en),
    .acc_first_o (acc_first),
    .done_o      (done)
  );

  ob_acc_avg #(
    .DATA_W   (DATA_W),
    .AVG_LOG2 (AVG_LOG2)
  ) u_avg (
    .clk_i    (clk),
    .rst_ni   (rst_int_n),
    .pix_i    (pix_i),
    .acc_en_i (acc_en),
    .first_i  (acc_first),
    .done_i   (done),
    .clamp_o  (clamp_o),
    .upd_o    (clamp_upd_o)
  );

  // strobe lands two edges after the last sample and never during sampling
  assert_upd_timing_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    clamp_upd_o |-> ($past(acc_en, 2) && !$past(acc_en)));

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_int_n |=> (clamp_o == '0) && !clamp_upd_o);

endmodule

// File: tb/ob_clamp_avg_test.sv
module ob_clamp_avg_test;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] pix = '0;
  logic       mark = 1'b0;
  logic       inv = 1'b0;
  logic [9:0] clamp;
  logic       upd;

  int errors = 0;
  int checks = 0;
  int upd_seen = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ob_clamp_avg uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_i       (pix),
    .ob_mark_i   (mark),
    .ob_inv_i    (inv),
    .clamp_o     (clamp),
    .clamp_upd_o (upd)
  );

  // behavioural reference: offset counter, sample queue, integer sum
  int         m_off;
  bit         m_prev;
  logic [9:0] m_clamp;
  bit         m_upd;
  logic [9:0] m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_off   = -1;
      m_prev  = 1'b1;
      m_clamp = '0;
      m_upd   = 1'b0;
      m_q.delete();
    end else begin
      bit a;
      a = mark ^ inv;
      m_upd = 1'b0;
      if (m_off < 0) begin
        if (a && !m_prev) m_off = 1;
      end else if (m_off <= 2 && !a) begin
        m_off = -1;
        m_q.delete();
      end else begin
        if (m_off >= 5 && m_off <= 12) m_q.push_back(pix);
        if (m_off == 13) begin
          int s;
          s = 0;
          foreach (m_q[i]) s += m_q[i];
          m_clamp = 10'(s / 8);
          m_upd   = 1'b1;
          m_q.delete();
          m_off   = -1;
        end else begin
          m_off++;
        end
      end
      m_prev = a;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: compare the outputs, then drive the next inputs (falling edge)
  task automatic tick(input logic [9:0] p, input bit a);
    @(negedge clk);
    if (cmp_on) begin
      check(clamp === m_clamp, "R6 clamp vs model", int'(clamp), int'(m_clamp));
      check(upd === m_upd, "R7 strobe vs model", int'(upd), int'(m_upd));
      if (upd === 1'b1) upd_seen++;
    end
    pix  = p;
    mark = a ^ inv;
  endtask

  // mode 0: constant, 1: base*offset, 2: base except base-1 at offset 12
  task automatic run_pulse(input int width, input int len, input int mode, input int base);
    for (int k = 0; k < len; k++) begin
      int v;
      case (mode)
        0:       v = base;
        1:       v = base * k;
        default: v = (k == 12) ? base - 1 : base;
      endcase
      tick(10'(v), k < width);
    end
  endtask

  task automatic set_pol(input bit v);
    tick(pix, 1'b0);
    inv  = v;
    mark = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(clamp === 10'd0, "R1 clamp after reset", int'(clamp), 0);
    check(upd === 1'b0, "R1 strobe after reset", int'(upd), 0);
    cmp_on = 1'b1;
    run_pulse(0, 20, 0, 0);
    check(upd_seen == 0, "R1 no window opens", upd_seen, 0);

    // R5 boundary: three active clocks accepted; R4 constant mean
    base_cnt = upd_seen;
    run_pulse(3, 16, 0, 100);
    check(clamp === 10'd100, "R4 constant mean", int'(clamp), 100);
    check(upd_seen - base_cnt == 1, "R7 one strobe", upd_seen - base_cnt, 1);

    // R3: ramp 50*k sampled at offsets 5..12 -> 3400/8 = 425
    run_pulse(3, 16, 1, 50);
    check(clamp === 10'd425, "R3 window offsets", int'(clamp), 425);

    // R5: two-clock pulse rejected, R6: level held
    base_cnt = upd_seen;
    run_pulse(2, 20, 0, 999);
    check(clamp === 10'd425, "R5 short pulse ignored", int'(clamp), 425);
    check(upd_seen - base_cnt == 0, "R5 no strobe", upd_seen - base_cnt, 0);

    // R2: active-low marker, full scale
    set_pol(1'b1);
    run_pulse(0, 6, 0, 0);
    base_cnt = upd_seen;
    run_pulse(3, 16, 0, 1023);
    check(clamp === 10'd1023, "R2 active-low marker", int'(clamp), 1023);
    check(upd_seen - base_cnt == 1, "R2 strobe count", upd_seen - base_cnt, 1);

    // R4: floor, 7*7+6 = 55 -> 6
    run_pulse(3, 16, 2, 7);
    check(clamp === 10'd6, "R4 floor of mean", int'(clamp), 6);

    // R2: active-high level with inverted select does not trigger
    base_cnt = upd_seen;
    run_pulse(0, 20, 0, 300);
    check(upd_seen - base_cnt == 0, "R2 inactive level", upd_seen - base_cnt, 0);
    check(clamp === 10'd6, "R2 level held", int'(clamp), 6);

    // R9: long marker starts one window
    set_pol(1'b0);
    run_pulse(0, 4, 0, 0);
    base_cnt = upd_seen;
    run_pulse(30, 40, 0, 512);
    check(clamp === 10'd512, "R9 long marker mean", int'(clamp), 512);
    check(upd_seen - base_cnt == 1, "R9 single window", upd_seen - base_cnt, 1);

    // R8: second edge at offset 7 inside an open window is ignored
    base_cnt = upd_seen;
    for (int k = 0; k < 30; k++) tick(10'd200, (k < 3) || (k >= 7 && k <= 10));
    check(upd_seen - base_cnt == 1, "R8 edge in window ignored", upd_seen - base_cnt, 1);
    check(clamp === 10'd200, "R8 clamp value", int'(clamp), 200);

    // R8: fresh edge at offset 14 starts a new window
    base_cnt = upd_seen;
    for (int k = 0; k < 32; k++) tick((k < 14) ? 10'd300 : 10'd40, (k < 3) || (k >= 14 && k <= 16));
    check(upd_seen - base_cnt == 2, "R8 back-to-back windows", upd_seen - base_cnt, 2);
    check(clamp === 10'd40, "R8 second window mean", int'(clamp), 40);

    run_pulse(0, 4, 0, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule